// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter with Coherence Flag

This block is a free-running cycle counter, 64 bits wide by default. Software reads it as two 32-bit halves through a small register port. The counter is made of two equal word segments, and the lower segment carries into the upper one. Software does not get a latched snapshot. Instead, a tracking state machine watches the read order: lower word, then upper word, then control. When software reads the control word, bit 31 tells it whether the two halves it just read belong to the same count. If that bit is clear, software repeats the three reads.

The coherence flag is cleared in two cases: the lower word wraps (so the upper word moves) after the lower word has been read, or the core takes an interrupt or exception in that window. The interrupt is reported on the `irq_taken` pulse.

The counter resets to zero and stays disabled until software sets bit 0 of the control word. Reads are combinational, so `reg_rdata` is valid in the same cycle as `reg_rd`. The effects of a read on the tracker take place at the next clock edge. An `irq_taken` pulse in a cycle counts as taken after that cycle's register access.

Top module: `coherent_split_counter`

## Requirements
- R1: After reset the counter is zero and counting is disabled. A read of the control word (address 0x103) returns 0.
- R2: Writing the control word with bit 0 = 1 enables counting, and the count then rises by one on every clock. Writing bit 0 = 0 freezes the count. Bit 0 of a control read returns the enable state.
- R3: A read at address 0x104 returns the lower word and a read at 0x105 returns the upper word, each zero-extended to 32 bits, in the same cycle as the read strobe. Any other address, or a cycle with no read strobe, returns 0.
- R4: Each wrap of the lower word adds one to the upper word. The full count wraps from all ones to zero and keeps counting.
- R5: A read of the lower word starts a new tracking sequence and presets the coherence flag to 1. The flag is preset to 0 instead if the lower word wraps at the clock edge ending that read cycle.
- R6: A lower-word wrap at the edge ending any cycle after the lower-word read and before the upper-word read clears the coherence flag. A wrap at the edge ending the upper-word read cycle leaves the flag at 1.
- R7: An `irq_taken` pulse in any cycle after the lower-word read and before the upper-word read clears the coherence flag. A pulse in the upper-word read cycle, or later, leaves the flag unchanged.
- R8: A control read that follows a lower-then-upper read pair returns the coherence flag in bit 31 and ends the sequence. A second control read then returns bit 31 = 0.
- R9: A control read with no complete lower-then-upper pair before it (idle, or lower word read alone) returns bit 31 = 0.
- R10: Writes to the lower-word and upper-word addresses are ignored and leave the count unchanged.
- R11: A lower-word read at any point restarts the sequence and discards the earlier coherence result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| irq_taken | input | 1 | Pulse: core took an interrupt or exception |

## Verification
The bench builds the block with WORD_W = 8, so the total count is 16 bits wide. With that setting the lower word wraps every 256 cycles, which makes it cheap to place a read pair exactly around a wrap edge. The full count also returns to zero within about 65,000 cycles, so the whole-counter wrap is reached in the same run. Register and data widths stay at their default values, so the coherence flag is checked at bit 31 and the addresses are the ones software uses.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE      = 2'd0,
    TRK_WAIT_HI   = 2'd1,
    TRK_WAIT_CTRL = 2'd2
  } trk_state_e;

endpackage

// File: rtl/csc_counter.sv
module csc_counter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic              lo_wrap
);
  localparam int unsigned NSEG = 2;

  function automatic logic [WORD_W-1:0] seg_next(input logic [WORD_W-1:0] v,
                                                 input logic step);
    return v + WORD_W'(step);
  endfunction

  function automatic logic seg_full(input logic [WORD_W-1:0] v);
    return &v;
  endfunction

  logic [NSEG:0] step_chain;
  assign step_chain[0] = en;

  for (genvar g = 0; g < NSEG; g++) begin : gen_seg
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= seg_next(q, step_chain[g]);
    end
    assign step_chain[g+1] = step_chain[g] & seg_full(q);
  end

  assign lo_q    = gen_seg[0].q;
  assign hi_q    = gen_seg[1].q;
  assign lo_wrap = step_chain[1];

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    en && !lo_wrap |=> lo_q == WORD_W'($past(lo_q) + 1'b1) && $stable(hi_q));
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lo_q) && $stable(hi_q));
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> lo_q == '0 && hi_q == WORD_W'($past(hi_q) + 1'b1));
endmodule

// File: rtl/csc_tracker.sv
module csc_tracker
  import csc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  input  logic rd_ctrl,
  input  logic irq,
  input  logic lo_wrap,
  output logic report
);
  trk_state_e st_q;
  logic       coh_q;

  logic seq_start, seq_pair_done, window_open, window_spoil;
  assign seq_start     = rd_lo;
  assign seq_pair_done = (st_q == TRK_WAIT_HI) && rd_hi;
  assign window_open   = (st_q == TRK_WAIT_HI) && !rd_hi && !rd_ctrl && !rd_lo;
  assign window_spoil  = window_open && (lo_wrap || irq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TRK_IDLE;
      coh_q <= 1'b0;
    end else if (seq_start) begin
      st_q  <= TRK_WAIT_HI;
      coh_q <= !lo_wrap;
    end else if (rd_ctrl) begin
      st_q  <= TRK_IDLE;
    end else if (seq_pair_done) begin
      st_q  <= TRK_WAIT_CTRL;
    end else if (window_spoil) begin
      coh_q <= 1'b0;
    end
  end

  assign report = (st_q == TRK_WAIT_CTRL) && coh_q;

  a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !lo_wrap |=> st_q == TRK_WAIT_HI && coh_q);
  a_r5_start_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && lo_wrap |=> !coh_q);
  a_r6_carry_spoils: assert property (@(posedge clk) disable iff (!rst_n)
    window_open && lo_wrap |=> !coh_q && st_q == TRK_WAIT_HI);
  a_r7_irq_spoils: assert property (@(posedge clk) disable iff (!rst_n)
    window_open && irq |=> !coh_q && st_q == TRK_WAIT_HI);
  a_r8_ctrl_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> st_q == TRK_IDLE);
  a_r8_pair_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    seq_pair_done |=> st_q == TRK_WAIT_CTRL && coh_q == $past(coh_q));
endmodule

// File: rtl/csc_regif.sv
module csc_regif #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h103,
  parameter logic [ADDR_W-1:0] ADDR_LO   = 'h104,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 'h105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              wbit0,
  input  logic [WORD_W-1:0] lo_q,
  input  logic [WORD_W-1:0] hi_q,
  input  logic              report,
  output logic              rd_lo,
  output logic              rd_hi,
  output logic              rd_ctrl,
  output logic              en_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned FLAG_BIT = DATA_W - 1;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic flag, input logic en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    w[0] = en;
    return w;
  endfunction

  initial assert (WORD_W <= DATA_W && WORD_W > 0);

  logic wr_ctrl;
  assign rd_lo   = rd && (addr == ADDR_LO);
  assign rd_hi   = rd && (addr == ADDR_HI);
  assign rd_ctrl = rd && (addr == ADDR_CTRL);
  assign wr_ctrl = wr && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (wr_ctrl) en_q <= wbit0;
  end

  always_comb begin
    rdata = '0;
    if (rd_lo)        rdata = DATA_W'(lo_q);
    else if (rd_hi)   rdata = DATA_W'(hi_q);
    else if (rd_ctrl) rdata = ctrl_word(report, en_q);
  end

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> en_q == $past(wbit0));
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rdata == '0);
endmodule

// File: rtl/coherent_split_counter.sv
module coherent_split_counter #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h103,
  parameter logic [ADDR_W-1:0] ADDR_LO   = 'h104,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 'h105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_taken
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic lo_wrap, en_q, report, rd_lo, rd_hi, rd_ctrl;
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  csc_regif #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wbit0(reg_wdata[0]), .lo_q(lo_q), .hi_q(hi_q), .report(report),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_ctrl(rd_ctrl), .en_q(en_q),
    .rdata(reg_rdata)
  );

  csc_counter #(.WORD_W(WORD_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .lo_q(lo_q), .hi_q(hi_q), .lo_wrap(lo_wrap)
  );

  csc_tracker u_tracker (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_ctrl(rd_ctrl),
    .irq(irq_taken), .lo_wrap(lo_wrap), .report(report)
  );

  a_r10_data_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !en_q && (reg_addr == ADDR_LO || reg_addr == ADDR_HI)
      |=> $stable(lo_q) && $stable(hi_q));
  a_r9_ctrl_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl && $past(rd_ctrl) |-> !reg_rdata[DATA_W-1]);
endmodule

// File: tb/test_coherent_split_counter.sv
module test_coherent_split_counter;
  localparam int CLK_P  = 10;
  localparam int WORD_W = 8;
  localparam logic [11:0] A_CTRL = 12'h103, A_LO = 12'h104, A_HI = 12'h105;
  localparam longint unsigned WMASK = (64'd1 << WORD_W) - 1;
  localparam longint unsigned CMASK = (64'd1 << (2*WORD_W)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, irq_taken = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  longint unsigned m_cnt = 0;
  bit m_en = 0, m_coh = 0;
  int m_phase = 0; // 0 idle, 1 low seen, 2 pair seen

  always #(CLK_P/2) clk = ~clk;

  coherent_split_counter #(.WORD_W(WORD_W)) i_coherent_split_counter (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_taken(irq_taken)
  );

  function automatic logic [31:0] predict();
    logic [31:0] r = '0;
    if (reg_rd) begin
      if (reg_addr == A_LO)        r = 32'(m_cnt & WMASK);
      else if (reg_addr == A_HI)   r = 32'((m_cnt >> WORD_W) & WMASK);
      else if (reg_addr == A_CTRL) r = {(m_phase == 2) && m_coh, 30'd0, m_en};
    end
    return r;
  endfunction

  task automatic advance_model();
    bit wrap = m_en && ((m_cnt & WMASK) == WMASK);
    if (reg_rd && reg_addr == A_LO) begin
      m_phase = 1; m_coh = !wrap;
    end else if (reg_rd && reg_addr == A_CTRL) begin
      m_phase = 0;
    end else if (m_phase == 1) begin
      if (reg_rd && reg_addr == A_HI) m_phase = 2;
      else if (wrap || irq_taken) m_coh = 0;
    end
    if (m_en) m_cnt = (m_cnt + 1) & CMASK;
    if (reg_wr && reg_addr == A_CTRL) m_en = reg_wdata[0];
  endtask

  task automatic cyc(input logic [11:0] a, input logic rd, input logic wr,
                     input logic [31:0] wd, input logic irq, input string tag);
    logic [31:0] exp;
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; irq_taken = irq;
    #1;
    exp = predict();
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata actual %h expected %h (addr %h rd %0b)",
               tag, reg_rdata, exp, a, rd);
    end
    @(posedge clk);
    advance_model();
    @(negedge clk);
  endtask

  task automatic idle(input string tag);        cyc(A_LO, 0, 0, 0, 0, tag); endtask
  task automatic rd_at(input logic [11:0] a, input string tag); cyc(a, 1, 0, 0, 0, tag); endtask
  task automatic wr_at(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(a, 0, 1, d, 0, tag);
  endtask
  task automatic irq_pulse(input string tag);   cyc(A_LO, 0, 0, 0, 1, tag); endtask
  task automatic wait_lo(input longint unsigned v, input string tag);
    while ((m_cnt & WMASK) != v) idle(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_at(A_CTRL, "R1"); rd_at(A_LO, "R1"); rd_at(A_HI, "R1");
    rd_at(A_CTRL, "R1");
    // R3 unmapped address and no strobe
    rd_at(12'h106, "R3"); rd_at(12'h102, "R3"); idle("R3");
    // R10 data writes while disabled
    wr_at(A_LO, 32'h55, "R10"); wr_at(A_HI, 32'hAA, "R10");
    rd_at(A_LO, "R10"); rd_at(A_HI, "R10");
    // R2 enable and count
    wr_at(A_CTRL, 32'h1, "R2");
    for (int i = 0; i < 12; i++) rd_at(A_LO, "R2");
    rd_at(A_CTRL, "R2");
    wr_at(A_CTRL, 32'h0, "R2");
    for (int i = 0; i < 5; i++) rd_at(A_LO, "R2");
    rd_at(A_CTRL, "R2");
    // R10 data writes while disabled keep count frozen
    wr_at(A_LO, 32'hFF, "R10"); rd_at(A_LO, "R10");
    wr_at(A_CTRL, 32'h8000_0001, "R2");
    // R10 while enabled
    wr_at(A_HI, 32'h7, "R10"); rd_at(A_HI, "R10"); rd_at(A_LO, "R10");
    // R8 clean pair
    rd_at(A_LO, "R8"); rd_at(A_HI, "R8"); rd_at(A_CTRL, "R8"); rd_at(A_CTRL, "R8");
    rd_at(A_LO, "R8"); idle("R8"); idle("R8"); rd_at(A_HI, "R8"); idle("R8"); rd_at(A_CTRL, "R8");
    // R9 no pair
    rd_at(A_CTRL, "R9");
    rd_at(A_LO, "R9"); rd_at(A_CTRL, "R9");
    rd_at(A_HI, "R9"); rd_at(A_CTRL, "R9");
    // R7 interrupt windows
    rd_at(A_LO, "R7"); irq_pulse("R7"); rd_at(A_HI, "R7"); rd_at(A_CTRL, "R7");
    rd_at(A_LO, "R7"); idle("R7"); irq_pulse("R7"); idle("R7"); rd_at(A_HI, "R7"); rd_at(A_CTRL, "R7");
    rd_at(A_LO, "R7"); cyc(A_HI, 1, 0, 0, 1, "R7"); rd_at(A_CTRL, "R7");
    rd_at(A_LO, "R7"); rd_at(A_HI, "R7"); irq_pulse("R7"); rd_at(A_CTRL, "R7");
    // R11 restart discards earlier result
    rd_at(A_LO, "R11"); irq_pulse("R11"); rd_at(A_LO, "R11"); rd_at(A_HI, "R11"); rd_at(A_CTRL, "R11");
    rd_at(A_LO, "R11"); rd_at(A_HI, "R11"); rd_at(A_LO, "R11"); idle("R11"); rd_at(A_CTRL, "R11");
    // R6 carry between the reads
    wait_lo(WMASK - 1, "R6");
    rd_at(A_LO, "R6"); idle("R6"); rd_at(A_HI, "R6"); rd_at(A_CTRL, "R6");
    // R5 low read in the wrapping cycle
    wait_lo(WMASK, "R5");
    rd_at(A_LO, "R5"); rd_at(A_HI, "R5"); rd_at(A_CTRL, "R5");
    // R6 carry on the upper-read edge does not spoil
    wait_lo(WMASK - 1, "R6");
    rd_at(A_LO, "R6"); rd_at(A_HI, "R6"); rd_at(A_CTRL, "R6");
    // R4 carry and full wrap
    for (int i = 0; i < 70000; i++) rd_at((i % 2) ? A_HI : A_LO, "R4");
    rd_at(A_CTRL, "R4");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule